// File: doc/BRIEF.md
# Request-paced transfer gate

This block decides, cycle by cycle, whether a transfer channel's datapath may move data. Software controls it through a mode register that holds a start bit, an external-start enable, a pause-mode enable and a four-bit burst-size exponent. The datapath reports its progress with a strobe that stands for one unit of `BEAT_BYTES` bytes. The block answers with a single move-enable level.

In pause mode, an active-low request pin paces the channel. Each new assertion of the pin grants one burst of 2^n bytes. When the burst is spent, the channel stops. A pin held low does not keep it running; only a fresh falling edge lets it continue. An edge that arrives while a burst is still running is stored, so the next burst follows with no gap. In external-start mode, setting the start bit only arms the channel. Data movement begins when an active-low start pin asserts. A halt pulse clears the start bit and the external-start enable and leaves the other fields as they are.

Both pins are asynchronous. Each passes through a two-flop synchroniser, and then a registered edge detector finds the new assertion.

Top module: `req_pace_gate`

## Requirements
- R1: Under reset and on the first cycle after it, `move_en` is 0, `bytes_done` is 0 and `mode_rdata` is 0.
- R2: A cycle with `mode_wr` high loads the mode register. The fields are: start at bit 0, external-start enable at bit 5, pause-mode enable at bit 6, and the burst exponent n at bits 27:24. Every other bit reads back as 0.
- R3: With pause mode and external start both off, `move_en` is 1 from the edge that sets the start bit until the start bit clears. In this mode `bytes_done` does not change. `move_en` is never 1 while the start bit is 0.
- R4: A write that sets the start bit from 0 with pause enabled clears `bytes_done` to 0. `move_en` then stays 0 until a request assertion arrives.
- R5: Once `req_n` falls, `move_en` in pause mode becomes 1 at the third rising edge (two synchroniser flops plus one edge register).
- R6: In pause mode, each cycle with `beat` and `move_en` both high adds `BEAT_BYTES` to `bytes_done`. `move_en` drops at the edge where `bytes_done` reaches 2^n. Holding `req_n` low does not resume the channel.
- R7: A new falling edge of `req_n` after a pause grants a fresh burst: `bytes_done` returns to 0 and `move_en` becomes 1.
- R8: A falling edge of `req_n` during a burst is remembered. At the edge where that burst ends, `bytes_done` returns to 0 and `move_en` stays 1.
- R9: Exponent values above `MAX_LOG2` (default 10) act as `MAX_LOG2`, so a burst never exceeds 1024 bytes.
- R10: With external start enabled, setting the start bit leaves `move_en` at 0. A falling edge of `xstart_n` raises `move_en` at the third rising edge. A level held low with no new edge has no effect.
- R11: A `halt` pulse clears the start bit and the external-start enable and keeps the other fields. `move_en` is 0 from the next edge. Halt takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | MODE_W | Mode register write data |
| halt | input | 1 | Stop pulse: clears the start bit and the external-start enable |
| req_n | input | 1 | Asynchronous active-low request pin |
| xstart_n | input | 1 | Asynchronous active-low external start pin |
| beat | input | 1 | Datapath progress strobe, one per `BEAT_BYTES` bytes |
| move_en | output | 1 | Datapath may move data this cycle |
| bytes_done | output | CNT_W | Bytes moved in the current burst |
| mode_rdata | output | MODE_W | Mode register read-back |

## Verification
The assertions check on every cycle the invariants that hold in any state. `move_en` never rises without the start bit. While the exponent is steady, the burst count stays below its limit whenever data may move. A paused channel never advances its count. A halt clears its two bits and stops movement. A fresh start in pause or external-start mode holds movement off. Only the bench's scenarios can show the timing and the edge behaviour. These are the exact three-edge latency through the synchronisers, the drop at exactly 2^n bytes, the refusal to resume on a held level, the stored mid-burst edge that chains two bursts, and the clamp of large exponents to 1024.

// File: rtl/req_pace_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the request-paced transfer gate.
// Assumes a mode register of at least 28 bits, so the exponent field fits.
package req_pace_pkg;

    localparam int BIT_START   = 0;
    localparam int BIT_XSTART  = 5;
    localparam int BIT_PAUSE   = 6;
    localparam int CNT_LSB     = 24;
    localparam int CNT_FIELD_W = 4;

    typedef struct packed {
        logic [CNT_FIELD_W-1:0] cnt_log2;
        logic                   pause_en;
        logic                   xs_en;
        logic                   start;
    } mode_t;

endpackage

// File: rtl/req_pace_sync.sv
`timescale 1ns/1ps
// Synchroniser with falling-edge detect for one asynchronous active-low pin.
// Assumes the pin idles high; the whole chain resets to 1 so that leaving
// reset cannot create a false edge. 'fall' is high for one cycle, STAGES
// edges after the pin goes low.
module req_pace_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // First synchroniser stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= pin_n;
    end

    // Remaining synchroniser stages.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b1;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // Previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    // A new assertion is high-to-low on the synchronised level.
    always_comb fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/req_pace_mode.sv
`timescale 1ns/1ps
// Mode register. It holds the start bit, the external-start enable, the
// pause enable and the burst exponent. Halt wins over a write in the same
// cycle. 'start_pulse' marks a write that sets the start bit from 0.
// Assumes MODE_W >= CNT_LSB + CNT_FIELD_W.
module req_pace_mode
    import req_pace_pkg::*;
#(
    parameter int MODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              halt,
    input  logic [MODE_W-1:0] wdata,
    output mode_t             mode,
    output logic              start_pulse,
    output logic [MODE_W-1:0] rdata
);

    localparam logic [MODE_W-1:0] FIELD_MASK =
        (MODE_W'(1) << BIT_START) | (MODE_W'(1) << BIT_XSTART) |
        (MODE_W'(1) << BIT_PAUSE) |
        (MODE_W'((1 << CNT_FIELD_W) - 1) << CNT_LSB);

    mode_t             mode_q;
    mode_t             wr_fields;
    logic [MODE_W-1:0] wdata_unused;

    // Pull the named fields out of the write data.
    always_comb begin
        wr_fields.start    = wdata[BIT_START];
        wr_fields.xs_en    = wdata[BIT_XSTART];
        wr_fields.pause_en = wdata[BIT_PAUSE];
        wr_fields.cnt_log2 = wdata[CNT_LSB +: CNT_FIELD_W];
        wdata_unused       = wdata & ~FIELD_MASK;
    end

    // Register update: halt clears two bits, otherwise a write loads all fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (halt) begin
            mode_q.start <= 1'b0;
            mode_q.xs_en <= 1'b0;
        end else if (wr) begin
            mode_q <= wr_fields;
        end
    end

    // Start is issued only on a 0-to-1 write of the start bit.
    always_comb start_pulse = wr && !halt && wr_fields.start && !mode_q.start;

    // Read-back image with every bit outside the fields at zero.
    always_comb begin
        rdata                            = '0;
        rdata[BIT_START]                 = mode_q.start;
        rdata[BIT_XSTART]                = mode_q.xs_en;
        rdata[BIT_PAUSE]                 = mode_q.pause_en;
        rdata[CNT_LSB +: CNT_FIELD_W]    = mode_q.cnt_log2;
    end

    always_comb mode = mode_q;

endmodule

// File: rtl/req_pace_credit.sv
`timescale 1ns/1ps
// Burst credit tracker for pause mode. A request edge grants one burst of
// 'limit' bytes. An edge seen during a burst is stored and renews the
// credit at the end of that burst. Assumes 'limit' is a power of two no
// larger than 2^(CNT_W-1).
module req_pace_credit #(
    parameter int CNT_W      = 11,
    parameter int BEAT_BYTES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             fall,
    input  logic             beat_ok,
    input  logic [CNT_W-1:0] limit,
    output logic             credit,
    output logic [CNT_W-1:0] bytes_done
);

    localparam int SUM_W = CNT_W + 1;

    logic             credit_q;
    logic             pending_q;
    logic [CNT_W-1:0] bytes_q;
    logic [SUM_W-1:0] next_sum;
    logic             exhaust;
    logic [CNT_W-1:0] next_sat;

    // Next count, and whether this edge spends the burst.
    always_comb begin
        next_sum = {1'b0, bytes_q} + (beat_ok ? SUM_W'(BEAT_BYTES) : SUM_W'(0));
        exhaust  = credit_q && (next_sum >= {1'b0, limit});
        next_sat = exhaust ? limit : next_sum[CNT_W-1:0];
    end

    // Credit, stored request and byte count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            credit_q  <= 1'b0;
            pending_q <= 1'b0;
            bytes_q   <= '0;
        end else if (!active) begin
            credit_q  <= 1'b0;
            pending_q <= 1'b0;
        end else if (!credit_q) begin
            if (fall) begin
                credit_q <= 1'b1;
                bytes_q  <= '0;
            end
        end else if (exhaust) begin
            if (pending_q || fall) begin
                bytes_q   <= '0;
                pending_q <= 1'b0;
            end else begin
                credit_q <= 1'b0;
                bytes_q  <= next_sat;
            end
        end else begin
            bytes_q <= next_sat;
            if (fall) pending_q <= 1'b1;
        end
    end

    always_comb begin
        credit     = credit_q;
        bytes_done = bytes_q;
    end

endmodule

// File: rtl/req_pace_gate.sv
`timescale 1ns/1ps
// Request-paced transfer gate (top). It combines the mode register, two pin
// synchronisers and the burst credit tracker into one move-enable output.
// Assumes 'beat' is only meaningful while move_en is high and stands for
// BEAT_BYTES bytes.
module req_pace_gate
    import req_pace_pkg::*;
#(
    parameter int MODE_W      = 32,
    parameter int MAX_LOG2    = 10,
    parameter int SYNC_STAGES = 2,
    parameter int BEAT_BYTES  = 1,
    parameter int CNT_W       = MAX_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              halt,
    input  logic              req_n,
    input  logic              xstart_n,
    input  logic              beat,
    output logic              move_en,
    output logic [CNT_W-1:0]  bytes_done,
    output logic [MODE_W-1:0] mode_rdata
);

    mode_t                  mode;
    logic                   start_pulse;
    logic                   req_fall;
    logic                   xs_fall;
    logic                   xs_seen_q;
    logic [CNT_FIELD_W-1:0] eff_log2;
    logic [CNT_W-1:0]       limit;
    logic                   credit;
    logic                   run;
    logic                   pause_clear;
    logic                   pause_active;

    req_pace_mode #(.MODE_W(MODE_W)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (mode_wr),
        .halt        (halt),
        .wdata       (mode_wdata),
        .mode        (mode),
        .start_pulse (start_pulse),
        .rdata       (mode_rdata)
    );

    req_pace_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (req_n),
        .fall  (req_fall)
    );

    req_pace_sync #(.STAGES(SYNC_STAGES)) u_xs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (xstart_n),
        .fall  (xs_fall)
    );

    // Burst limit from the exponent, clamped to the largest allowed size.
    always_comb begin
        eff_log2 = (int'(mode.cnt_log2) > MAX_LOG2) ? CNT_FIELD_W'(MAX_LOG2)
                                                    : mode.cnt_log2;
        limit    = CNT_W'(1) << eff_log2;
    end

    // Remember an external start assertion while the channel is armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode.start)          xs_seen_q <= 1'b0;
        else if (mode.xs_en && xs_fall)     xs_seen_q <= 1'b1;
    end

    // Credit tracking is live only while started in pause mode.
    always_comb begin
        pause_clear  = start_pulse && mode_wdata[BIT_PAUSE];
        pause_active = mode.start && mode.pause_en;
    end

    req_pace_credit #(.CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pause_clear),
        .active     (pause_active),
        .fall       (req_fall),
        .beat_ok    (beat && move_en),
        .limit      (limit),
        .credit     (credit),
        .bytes_done (bytes_done)
    );

    // Final gate: started, start condition met, and credit when pacing.
    always_comb begin
        run     = mode.start && (!mode.xs_en || xs_seen_q);
        move_en = run && (!mode.pause_en || credit);
    end

endmodule

// File: rtl/req_pace_gate_chk.sv
`timescale 1ns/1ps
// Assertion checker for req_pace_gate, attached by the bind below.
module req_pace_gate_chk #(
    parameter int MAX_LOG2 = 10,
    parameter int CNT_W    = MAX_LOG2 + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic             wr_start,
    input logic             wr_xs,
    input logic             wr_pause,
    input logic             halt,
    input logic             move_en,
    input logic [CNT_W-1:0] bytes_done,
    input logic             rd_start,
    input logic             rd_xs,
    input logic             rd_pause,
    input logic [3:0]       rd_log2
);

    logic [CNT_W-1:0] chk_limit;

    // Expected burst limit, worked out from the read-back exponent.
    always_comb begin
        if (int'(rd_log2) > MAX_LOG2) chk_limit = CNT_W'(1) << MAX_LOG2;
        else                          chk_limit = CNT_W'(1) << rd_log2;
    end

    assert_move_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        move_en |-> rd_start);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wr_start && wr_pause && !halt && !rd_start)
        |=> (bytes_done == '0) && !move_en);

    assert_burst_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (move_en && rd_pause && $stable(rd_log2)) |-> (bytes_done < chk_limit));

    assert_paused_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!move_en && rd_pause && $stable(rd_log2))
        |=> ($stable(bytes_done) || bytes_done == '0));

    assert_xstart_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wr_start && wr_xs && !halt && !rd_start) |=> !move_en);

    assert_halt_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!rd_start && !rd_xs && !move_en));

endmodule

bind req_pace_gate req_pace_gate_chk #(.MAX_LOG2(MAX_LOG2), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .wr_start   (mode_wdata[0]),
    .wr_xs      (mode_wdata[5]),
    .wr_pause   (mode_wdata[6]),
    .halt       (halt),
    .move_en    (move_en),
    .bytes_done (bytes_done),
    .rd_start   (mode_rdata[0]),
    .rd_xs      (mode_rdata[5]),
    .rd_pause   (mode_rdata[6]),
    .rd_log2    (mode_rdata[27:24])
);

// File: tb/req_pace_gate_bench.sv
`timescale 1ns/1ps
// Scoreboard bench. Driver tasks set inputs just after a falling clock
// edge and queue the outputs expected after the next rising edge. The
// monitor pops and compares at the following falling edge.
module req_pace_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [31:0] mode_wdata = '0;
    logic        halt = 1'b0;
    logic        req_n = 1'b1;
    logic        xstart_n = 1'b1;
    logic        beat = 1'b0;
    logic        move_en;
    logic [10:0] bytes_done;
    logic [31:0] mode_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        bit          mv;
        int          bytes;
        bit          chk_mode;
        logic [31:0] mode;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    req_pace_gate u_req_pace_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .halt       (halt),
        .req_n      (req_n),
        .xstart_n   (xstart_n),
        .beat       (beat),
        .move_en    (move_en),
        .bytes_done (bytes_done),
        .mode_rdata (mode_rdata)
    );

    // Monitor: compare the outputs with the oldest expectation.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (move_en !== e.mv) begin
                errors++;
                $display("FAIL %s move_en actual=%0b expected=%0b", e.req, move_en, e.mv);
            end
            checks++;
            if (int'(bytes_done) != e.bytes) begin
                errors++;
                $display("FAIL %s bytes_done actual=%0d expected=%0d", e.req, bytes_done, e.bytes);
            end
            if (e.chk_mode) begin
                checks++;
                if (mode_rdata !== e.mode) begin
                    errors++;
                    $display("FAIL %s mode_rdata actual=%h expected=%h", e.req, mode_rdata, e.mode);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Queue the outputs expected after the coming rising edge, then advance.
    task automatic step(input string req, input bit mv, input int bytes,
                        input bit cm = 1'b0, input logic [31:0] m = '0);
        exp_t e;
        e.req = req; e.mv = mv; e.bytes = bytes; e.chk_mode = cm; e.mode = m;
        exp_q.push_back(e);
        tick();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick();
        // R1: reset state, while in reset and just after.
        step("R1", 0, 0, 1, 32'h0);
        step("R1", 0, 0, 1, 32'h0);
        rst_n = 1'b1;
        step("R1", 0, 0, 1, 32'h0);

        // R2: only the named fields are stored.
        mode_wr = 1'b1; mode_wdata = 32'hFFFF_FF9E;
        step("R2", 0, 0, 1, 32'h0F00_0000);
        mode_wr = 1'b0;

        // R3: plain start, no pacing.
        mode_wr = 1'b1; mode_wdata = 32'h0000_0001;
        step("R3", 1, 0, 1, 32'h0000_0001);
        mode_wr = 1'b0; beat = 1'b1;
        step("R3", 1, 0);
        step("R3", 1, 0);
        beat = 1'b0;
        halt = 1'b1;
        step("R11", 0, 0, 1, 32'h0);
        halt = 1'b0;
        step("R11", 0, 0);

        // R4: start in pause mode with 4-byte bursts.
        mode_wr = 1'b1; mode_wdata = 32'h0200_0041;
        step("R4", 0, 0, 1, 32'h0200_0041);
        mode_wr = 1'b0;
        step("R4", 0, 0);

        // R5: the request edge reaches the gate after three edges.
        req_n = 1'b0;
        step("R5", 0, 0);
        step("R5", 0, 0);
        step("R5", 1, 0);

        // R6: four bytes, then pause while the request stays low.
        beat = 1'b1;
        step("R6", 1, 1);
        step("R6", 1, 2);
        step("R6", 1, 3);
        step("R6", 0, 4);
        step("R6", 0, 4);
        step("R6", 0, 4);
        step("R6", 0, 4);
        beat = 1'b0;

        // R7: a fresh assertion grants a new burst.
        req_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R7", 0, 4);
        req_n = 1'b0;
        step("R7", 0, 4);
        step("R7", 0, 4);
        step("R7", 1, 0);

        // R8: an edge during the burst chains the next burst.
        req_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R8", 1, 0);
        req_n = 1'b0;
        for (int i = 0; i < 4; i++) step("R8", 1, 0);
        beat = 1'b1;
        step("R8", 1, 1);
        step("R8", 1, 2);
        step("R8", 1, 3);
        step("R8", 1, 0);
        step("R8", 1, 1);
        step("R8", 1, 2);
        step("R8", 1, 3);
        step("R8", 0, 4);
        beat = 1'b0;

        // R11: halt keeps the pause bit and the exponent.
        halt = 1'b1;
        step("R11", 0, 4, 1, 32'h0200_0040);
        halt = 1'b0;

        // R9: exponent 12 is clamped to 1024 bytes.
        req_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R9", 0, 4);
        mode_wr = 1'b1; mode_wdata = 32'h0C00_0041;
        step("R4", 0, 0, 1, 32'h0C00_0041);
        mode_wr = 1'b0;
        req_n = 1'b0;
        step("R9", 0, 0);
        step("R9", 0, 0);
        step("R9", 1, 0);
        beat = 1'b1;
        for (int i = 1; i < 1024; i++) step("R9", 1, i);
        step("R9", 0, 1024);
        step("R9", 0, 1024);
        beat = 1'b0;
        halt = 1'b1;
        step("R11", 0, 1024, 1, 32'h0C00_0040);
        halt = 1'b0;

        // R10: external start holds off movement until its pin asserts.
        req_n = 1'b1;
        mode_wr = 1'b1; mode_wdata = 32'h0000_0021;
        step("R10", 0, 1024, 1, 32'h0000_0021);
        mode_wr = 1'b0;
        for (int i = 0; i < 3; i++) step("R10", 0, 1024);
        xstart_n = 1'b0;
        step("R10", 0, 1024);
        step("R10", 0, 1024);
        step("R10", 1, 1024);
        step("R10", 1, 1024);
        halt = 1'b1;
        step("R11", 0, 1024, 1, 32'h0);
        halt = 1'b0;
        step("R11", 0, 1024);

        // R10: re-arm with the start pin still low; no new edge, no start.
        mode_wr = 1'b1; mode_wdata = 32'h0000_0021;
        step("R10", 0, 1024, 1, 32'h0000_0021);
        mode_wr = 1'b0;
        for (int i = 0; i < 4; i++) step("R10", 0, 1024);

        // R11: halt wins over a write in the same cycle.
        halt = 1'b1; mode_wr = 1'b1; mode_wdata = 32'h0000_0041;
        step("R11", 0, 1024, 1, 32'h0);
        halt = 1'b0; mode_wr = 1'b0;
        step("R11", 0, 1024);

        tick();
        tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule